// File: doc/BRIEF.md
# Interleaved Bank Column Address Counter

This block produces the column address for a memory made of two DRAM banks that share one data bus. Word-address bit 2 chooses the bank (0 = even, 1 = odd), and a 7-bit counter supplies the column. While one bank drives the bus, the other can already be addressed for the following word. A burst begins with a start strobe that carries the first byte address. Each later beat is marked by an advance pulse, which moves the transfer to the other bank.

The bank-select output flips on every beat. The column counter steps only when the transfer returns from the odd bank to the even bank, because both banks of one pair use the same column. A burst that begins on the odd bank is a special case. One clock after the load, the counter steps by one on its own, so the even bank is set up a word ahead. That early step counts as the step for the first odd-to-even beat of the burst, so it is never applied twice. Bursts never cross a 1 KB boundary, so no carry past address bit 9 is needed. Wrap from column 127 to 0 is left undefined.

Top module: `ilv_col_addr`

## Requirements
- R1: While reset is asserted and after its release, the column output is 0 and the bank output is 0 (even).
- R2: A start strobe sampled at a clock edge makes the column output equal address bits [9:3] and the bank output equal address bit 2 after that edge.
- R3: After a start with address bit 2 = 0, the column stays at the loaded value until the first beat that moves from the odd bank to the even bank.
- R4: After a start with address bit 2 = 1 and no beat on the next edge, the column equals the loaded value plus 1 after that edge, and the bank stays odd (1).
- R5: Each advance pulse without a start toggles the bank output at the sampling edge.
- R6: A beat that moves from odd (1) to even (0) increments the column by one. The exception is the first such beat after an odd start, whose step was already taken by the early increment.
- R7: If a beat arrives on the edge right after an odd-start load, the column increases by exactly one in total and the bank becomes even.
- R8: The start strobe has priority over the advance pulse. A beat in the same cycle as a start has no effect on either output.
- R9: With neither start nor advance (and no pending early increment), both outputs hold.
- R10: Address bits outside [9:2] have no effect on either output.
- R11: Outside a load, the column changes per edge by either 0 or +1 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst start strobe, one cycle |
| addr_i | input | ADDR_W (32) | Byte address of the first word, valid with start_i |
| beat_i | input | 1 | Advance to the next word of the burst |
| col_o | output | COL_W (7) | Column address for both banks |
| bank_odd_o | output | 1 | Bank select: 0 even, 1 odd |

## Verification
The bench targets the odd-start path most closely. A design that stepped again on the first odd-to-even beat would skip a column for the even bank. A design that left out the early step would make the even bank re-read the word that was just fetched. The bench also puts a beat right after an odd-start load, where a design that merges the two steps wrongly would jump by two. It asserts a start together with a beat to show that a design with the wrong priority toggles the bank or steps the column. It drives addresses with the upper and lower bits set to catch a counter loaded from the wrong slice.

// File: rtl/icc_pkg.sv
package icc_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2
    } cnt_op_e;

    typedef struct packed {
        logic pend;   // early step scheduled for the next edge
        logic ahead;  // early step taken, next odd-to-even beat must not step
    } seq_t;

endpackage

// File: rtl/icc_op_sel.sv
module icc_op_sel
    import icc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  logic    start_odd_i,
    input  logic    beat_i,
    input  logic    bank_odd_i,
    output cnt_op_e op_o
);

    seq_t    seq_q, seq_d;
    cnt_op_e op_d;

    always_comb begin
        seq_d = seq_q;
        op_d  = OP_HOLD;
        if (start_i) begin
            op_d       = OP_LOAD;
            seq_d.pend  = start_odd_i;
            seq_d.ahead = 1'b0;
        end else if (seq_q.pend) begin
            op_d        = OP_INC;
            seq_d.pend  = 1'b0;
            seq_d.ahead = !beat_i;
        end else if (beat_i && bank_odd_i) begin
            if (seq_q.ahead) begin
                seq_d.ahead = 1'b0;
            end else begin
                op_d = OP_INC;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign op_o = op_d;

    // R6: the skip flag may only be set while the odd bank is active
    a_r6_ahead_on_odd: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ahead |-> bank_odd_i);

    // R8: a start always wins over a beat
    a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && beat_i) |-> (op_o == OP_LOAD));

endmodule

// File: rtl/icc_col_cnt.sv
module icc_col_cnt
    import icc_pkg::*;
#(
    parameter int COL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          op_i,
    input  logic [COL_W-1:0] load_val_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] col_q, col_d;

    always_comb begin
        col_d = col_q;
        unique case (op_i)
            OP_LOAD: col_d = load_val_i;
            OP_INC:  col_d = col_q + COL_W'(1);
            default: col_d = col_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign col_o = col_q;

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_HOLD) |=> $stable(col_q));

    a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_LOAD) |=> ((col_q == $past(col_q)) ||
                               (col_q == $past(col_q) + COL_W'(1))));

endmodule

// File: rtl/icc_bank_sel.sv
module icc_bank_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic start_odd_i,
    input  logic beat_i,
    output logic bank_odd_o
);

    logic bank_q, bank_d;

    always_comb begin
        bank_d = bank_q;
        if (start_i) begin
            bank_d = start_odd_i;
        end else if (beat_i) begin
            bank_d = !bank_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank_odd_o = bank_q;

    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && !start_i) |=> (bank_q != $past(bank_q)));

    a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (bank_q == $past(start_odd_i)));

endmodule

// File: rtl/ilv_col_addr.sv
module ilv_col_addr
    import icc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int COL_W    = 7,
    parameter int BANK_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              beat_i,
    output logic [COL_W-1:0]  col_o,
    output logic              bank_odd_o
);

    localparam int COL_LSB = BANK_BIT + 1;
    localparam int COL_MSB = BANK_BIT + COL_W;

    logic [COL_W-1:0] load_col;
    logic             start_odd;
    cnt_op_e          op;

    assign load_col  = addr_i[COL_MSB:COL_LSB];
    assign start_odd = addr_i[BANK_BIT];

    icc_op_sel u_op (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_odd_i (start_odd),
        .beat_i      (beat_i),
        .bank_odd_i  (bank_odd_o),
        .op_o        (op)
    );

    icc_col_cnt #(.COL_W(COL_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .load_val_i (load_col),
        .col_o      (col_o)
    );

    icc_bank_sel u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_odd_i (start_odd),
        .beat_i      (beat_i),
        .bank_odd_o  (bank_odd_o)
    );

    a_r2_col_load: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (col_o == $past(load_col)));

    // R4 and R7: the edge after an odd-start load steps the column once
    a_r4_early_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_i && start_odd) && !start_i)
            |=> (col_o == $past(col_o) + COL_W'(1)));

endmodule

// File: tb/sim_ilv_col_addr.sv
module sim_ilv_col_addr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        beat_i = 1'b0;
    logic [6:0]  col_o;
    logic        bank_odd_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ilv_col_addr u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .beat_i     (beat_i),
        .col_o      (col_o),
        .bank_odd_o (bank_odd_o)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // one edge, then sample 1 ns later; inputs are changed only here
    task automatic step(input logic s, input logic b, input logic [31:0] a);
        start_i = s;
        beat_i  = b;
        addr_i  = a;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        beat_i  = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(1'b0, 1'b0, 32'h0);
        chk("R1 col in reset", int'(col_o), 0);
        chk("R1 bank in reset", int'(bank_odd_o), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 32'h0);
        chk("R1 col after reset", int'(col_o), 0);
    endtask

    task automatic t_even_start;
        step(1'b1, 1'b0, 32'h0000_0128);
        chk("R2 even load col", int'(col_o), 'h25);
        chk("R2 even load bank", int'(bank_odd_o), 0);
        step(1'b0, 1'b0, 32'h0);
        chk("R3 even start no early step", int'(col_o), 'h25);
        step(1'b0, 1'b1, 32'h0);
        chk("R5 toggle to odd", int'(bank_odd_o), 1);
        chk("R3 col holds on even-to-odd", int'(col_o), 'h25);
        step(1'b0, 1'b1, 32'h0);
        chk("R5 toggle to even", int'(bank_odd_o), 0);
        chk("R6 step on odd-to-even", int'(col_o), 'h26);
        step(1'b0, 1'b1, 32'h0);
        step(1'b0, 1'b1, 32'h0);
        chk("R11 single step", int'(col_o), 'h27);
    endtask

    task automatic t_odd_start;
        step(1'b1, 1'b0, 32'h0000_0084);
        chk("R2 odd load col", int'(col_o), 'h10);
        chk("R2 odd load bank", int'(bank_odd_o), 1);
        step(1'b0, 1'b0, 32'h0);
        chk("R4 early step col", int'(col_o), 'h11);
        chk("R4 bank stays odd", int'(bank_odd_o), 1);
        step(1'b0, 1'b0, 32'h0);
        chk("R9 hold col", int'(col_o), 'h11);
        chk("R9 hold bank", int'(bank_odd_o), 1);
        step(1'b0, 1'b1, 32'h0);
        chk("R6 no double step", int'(col_o), 'h11);
        chk("R5 odd start toggles to even", int'(bank_odd_o), 0);
        step(1'b0, 1'b1, 32'h0);
        step(1'b0, 1'b1, 32'h0);
        chk("R6 later odd-to-even steps", int'(col_o), 'h12);
    endtask

    task automatic t_odd_immediate_beat;
        step(1'b1, 1'b0, 32'h0000_0204);
        chk("R2 load col 0x40", int'(col_o), 'h40);
        step(1'b0, 1'b1, 32'h0);
        chk("R7 merged step col", int'(col_o), 'h41);
        chk("R7 bank even", int'(bank_odd_o), 0);
        step(1'b0, 1'b1, 32'h0);
        chk("R7 even-to-odd holds", int'(col_o), 'h41);
        step(1'b0, 1'b1, 32'h0);
        chk("R7 next odd-to-even steps", int'(col_o), 'h42);
    endtask

    task automatic t_priority;
        step(1'b1, 1'b0, 32'h0000_0010);
        step(1'b0, 1'b1, 32'h0);
        chk("R8 setup odd bank", int'(bank_odd_o), 1);
        step(1'b1, 1'b1, 32'h0000_0308);
        chk("R8 start beats beat col", int'(col_o), 'h61);
        chk("R8 start beats beat bank", int'(bank_odd_o), 0);
        step(1'b0, 1'b0, 32'h0);
        chk("R8 no leftover step", int'(col_o), 'h61);
    endtask

    task automatic t_outside_bits;
        step(1'b1, 1'b0, 32'hFFFF_FC03);
        chk("R10 col ignores outer bits", int'(col_o), 0);
        chk("R10 bank ignores outer bits", int'(bank_odd_o), 0);
        step(1'b1, 1'b0, 32'hA5A5_A7FB);
        chk("R10 col all-ones field", int'(col_o), 'h7F);
        chk("R10 bank clear", int'(bank_odd_o), 0);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_even_start();
        t_odd_start();
        t_odd_immediate_beat();
        t_priority();
        t_outside_bits();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule